// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the status and control word of a floating-point unit. The arithmetic datapath sits next to it. Software writes the word through a load port, and only the bits in a fixed writable mask are kept. Each completed arithmetic operation reports five exception indications on the update port: invalid, divide-by-zero, overflow, underflow and inexact.

On every update the controller rebuilds the per-operation flag field from those indications. It merges the flags into a sticky cause field. When a raised cause is also enabled, it requests a trap. From the stored word it drives two controls back to the datapath: a truncating rounding select and a flush-to-zero enable.

Compare operations report their outcome to the controller. An ordered outcome writes a single test bit with the result of the comparison. An unordered outcome leaves the test bit alone and runs the normal exception update instead.

Word layout: rounding mode in bits 1:0, with round-to-zero coded as 01. Flags are in bits 6:2, enables in bits 11:7, causes in bits 17:12, and the denormal-flush bit is bit 18. The exception vector is ordered inexact (bit 0), underflow (1), overflow (2), divide-by-zero (3), invalid (4). Exception k maps to flag bit 2+k, enable bit 7+k and cause bit 12+k. Cause bit 17 has no matching flag.

Top module: `fpsc_ctrl`

## Requirements
- R1: A load stores `ld_data_i` ANDed with the writable mask, which defaults to 0x0007FFFF. Bits outside the mask read as zero.
- R2: `rnd_zero_o` is 1 only when bits 1:0 of the word hold 01. The codes 00, 10 and 11 give 0, which means round to nearest even.
- R3: `flush_zero_o` follows bit 18 of the word.
- R4: Every accepted update first clears flag bits 6:2, including when no indication is raised. Bits outside the flag and cause fields do not change.
- R5: For each raised indication k, flag bit 2+k is set. The new flags are ORed into cause bits 16:12. Older cause bits stay set, and cause bit 17 is untouched.
- R6: When an accepted update raises at least one indication and (cause bits 16:12 after the merge) AND (enable bits 11:7) is nonzero, `trap_o` pulses for exactly one cycle on the edge that captures the update. During that cycle `trap_code_o` reads 0x120; at all other times it reads 0. An update with no indication raises no trap, even when stale causes are enabled.
- R7: A compare with an ordered outcome writes the test bit `t_bit_o`. The relation codes are 0 less, 1 equal, 2 greater and 3 unordered. An equal-test (`cmp_gt_i`=0) writes 1 exactly for code 1. A greater-test writes 1 exactly for code 2.
- R8: An unordered compare leaves `t_bit_o` unchanged and performs the R4–R6 update using `exc_i`.
- R9: When a load and an update fall in the same cycle, the load wins. The word takes the masked load value and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_en_i | input | 1 | Load strobe |
| ld_data_i | input | 32 | Load value |
| upd_en_i | input | 1 | Arithmetic update strobe |
| exc_i | input | 5 | Exception indications (invalid, div0, overflow, underflow, inexact from MSB) |
| cmp_en_i | input | 1 | Compare result strobe |
| cmp_gt_i | input | 1 | 1 = greater-than test, 0 = equality test |
| cmp_rel_i | input | 2 | Compare relation code |
| csr_o | output | 32 | Stored status/control word |
| rnd_zero_o | output | 1 | Truncating rounding select |
| flush_zero_o | output | 1 | Denormal flush enable |
| trap_o | output | 1 | Trap request pulse |
| trap_code_o | output | 12 | Trap exception code |
| t_bit_o | output | 1 | Compare test bit |

## Verification
The assertions assume that the update strobe and the compare strobe are never high in the same cycle, since the datapath retires one operation at a time. One property checks this assumption directly. The directed tasks raise at most one of the two strobes per cycle. The only overlap they create on purpose is a load together with an update, which is the priority case. Each task sets up the word through a load before it checks the merge, so every expected value follows from a known starting state.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int CSR_W     = 32;
  localparam int EXC_N     = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = 7;
  localparam int CAUSE_LSB = 12;
  localparam int CAUSE_W   = 6;
  localparam int DN_BIT    = 18;
  localparam int CODE_W    = 12;
  localparam logic [RM_W-1:0]   RM_ZERO   = 2'b01;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;
endpackage

// File: rtl/fpsc_exc_merge.sv
module fpsc_exc_merge
  import fpsc_pkg::*;
(
  input  logic [CSR_W-1:0] csr_i,
  input  logic [EXC_N-1:0] exc_i,
  output logic [CSR_W-1:0] csr_nxt_o,
  output logic             raise_o
);
  logic [EXC_N-1:0] cause_new;
  logic [EXC_N-1:0] en_cur;

  assign en_cur = csr_i[EN_LSB +: EXC_N];

  // flags rebuilt per op, causes sticky
  for (genvar k = 0; k < EXC_N; k++) begin : g_bit
    assign cause_new[k] = csr_i[CAUSE_LSB+k] | exc_i[k];
  end

  always_comb begin
    csr_nxt_o = csr_i;
    csr_nxt_o[FLAG_LSB +: EXC_N]  = exc_i;
    csr_nxt_o[CAUSE_LSB +: EXC_N] = cause_new;
  end

  assign raise_o = (|exc_i) && (|(cause_new & en_cur));
endmodule

// File: rtl/fpsc_mode_dec.sv
module fpsc_mode_dec
  import fpsc_pkg::*;
(
  input  logic [CSR_W-1:0] csr_i,
  output logic             rnd_zero_o,
  output logic             flush_zero_o
);
  assign rnd_zero_o   = (csr_i[RM_LSB +: RM_W] == RM_ZERO);
  assign flush_zero_o = csr_i[DN_BIT];
endmodule

// File: rtl/fpsc_cmp_eval.sv
module fpsc_cmp_eval
  import fpsc_pkg::*;
(
  input  logic       cmp_en_i,
  input  logic       cmp_gt_i,
  input  logic [1:0] cmp_rel_i,
  output logic       t_wr_o,
  output logic       t_val_o,
  output logic       unord_o
);
  rel_e rel;
  assign rel     = rel_e'(cmp_rel_i);
  assign unord_o = cmp_en_i && (rel == REL_UN);
  assign t_wr_o  = cmp_en_i && (rel != REL_UN);
  assign t_val_o = cmp_gt_i ? (rel == REL_GT) : (rel == REL_EQ);
endmodule

// File: rtl/fpsc_ctrl.sv
module fpsc_ctrl
  import fpsc_pkg::*;
#(
  parameter logic [CSR_W-1:0] WR_MASK = 32'h0007_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [CSR_W-1:0]  ld_data_i,
  input  logic              upd_en_i,
  input  logic [EXC_N-1:0]  exc_i,
  input  logic              cmp_en_i,
  input  logic              cmp_gt_i,
  input  logic [1:0]        cmp_rel_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              rnd_zero_o,
  output logic              flush_zero_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o,
  output logic              t_bit_o
);
  logic [CSR_W-1:0] csr_q, csr_nxt;
  logic             raise, trap_q, t_q;
  logic             t_wr, t_val, unord, upd_acc;

  fpsc_exc_merge u_merge (
    .csr_i     (csr_q),
    .exc_i     (exc_i),
    .csr_nxt_o (csr_nxt),
    .raise_o   (raise)
  );

  fpsc_mode_dec u_mode (
    .csr_i        (csr_q),
    .rnd_zero_o   (rnd_zero_o),
    .flush_zero_o (flush_zero_o)
  );

  fpsc_cmp_eval u_cmp (
    .cmp_en_i  (cmp_en_i),
    .cmp_gt_i  (cmp_gt_i),
    .cmp_rel_i (cmp_rel_i),
    .t_wr_o    (t_wr),
    .t_val_o   (t_val),
    .unord_o   (unord)
  );

  assign upd_acc = upd_en_i || unord;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else if (ld_en_i) begin
      csr_q  <= ld_data_i & WR_MASK;
      trap_q <= 1'b0;
    end else if (upd_acc) begin
      csr_q  <= csr_nxt;
      trap_q <= raise;
    end else begin
      trap_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   t_q <= 1'b0;
    else if (t_wr) t_q <= t_val;
  end

  assign csr_o       = csr_q;
  assign trap_o      = trap_q;
  assign trap_code_o = trap_q ? TRAP_CODE : '0;
  assign t_bit_o     = t_q;
endmodule

// File: rtl/fpsc_ctrl_chk.sv
module fpsc_ctrl_chk
  import fpsc_pkg::*;
#(
  parameter logic [CSR_W-1:0] WR_MASK = 32'h0007_FFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_en_i,
  input logic [CSR_W-1:0]  ld_data_i,
  input logic              upd_en_i,
  input logic [EXC_N-1:0]  exc_i,
  input logic              cmp_en_i,
  input logic              cmp_gt_i,
  input logic [1:0]        cmp_rel_i,
  input logic [CSR_W-1:0]  csr_o,
  input logic              rnd_zero_o,
  input logic              flush_zero_o,
  input logic              trap_o,
  input logic [CODE_W-1:0] trap_code_o,
  input logic              t_bit_o
);
  AST_LOAD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> csr_o == ($past(ld_data_i) & WR_MASK)); // R1
  AST_FLAG_REBUILD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !ld_en_i) |=> csr_o[FLAG_LSB +: EXC_N] == $past(exc_i)); // R4
  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !ld_en_i) |=>
      (($past(csr_o[CAUSE_LSB +: EXC_N]) & ~csr_o[CAUSE_LSB +: EXC_N]) == '0)); // R5
  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($past(exc_i) != '0)); // R6
  AST_TRAP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_code_o == (trap_o ? TRAP_CODE : 12'h000)); // R6
  AST_UNORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && cmp_rel_i == 2'd3) |=> $stable(t_bit_o)); // R8
  AST_LOAD_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> !trap_o); // R9
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_en_i && cmp_en_i)); // R8
  AST_RND_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> rnd_zero_o == ($past(ld_data_i[1:0]) == 2'b01)); // R2
  AST_DN_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> flush_zero_o == $past(ld_data_i[DN_BIT])); // R3
endmodule

bind fpsc_ctrl fpsc_ctrl_chk #(.WR_MASK(WR_MASK)) u_chk (.*);

// File: tb/fpsc_ctrl_tb.sv
module fpsc_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_en_i = 1'b0;
  logic [31:0] ld_data_i = '0;
  logic        upd_en_i = 1'b0;
  logic [4:0]  exc_i = '0;
  logic        cmp_en_i = 1'b0;
  logic        cmp_gt_i = 1'b0;
  logic [1:0]  cmp_rel_i = '0;
  logic [31:0] csr_o;
  logic        rnd_zero_o, flush_zero_o, trap_o, t_bit_o;
  logic [11:0] trap_code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fpsc_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_en_i = 0; upd_en_i = 0; cmp_en_i = 0; exc_i = '0;
  endtask

  task automatic do_load(input logic [31:0] d);
    ld_en_i = 1; ld_data_i = d;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_upd(input logic [4:0] e);
    upd_en_i = 1; exc_i = e;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_cmp(input logic gt, input logic [1:0] rel, input logic [4:0] e);
    cmp_en_i = 1; cmp_gt_i = gt; cmp_rel_i = rel; exc_i = e;
    @(negedge clk_i);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 reset csr", csr_o, 32'h0);
    chk("R6 reset trap", {31'b0, trap_o}, 32'h0);
    chk("R7 reset t", {31'b0, t_bit_o}, 32'h0);
  endtask

  task automatic t_load_mask();
    do_load(32'hFFFF_FFFF);
    chk("R1 masked load", csr_o, 32'h0007_FFFF);
    chk("R3 flush on", {31'b0, flush_zero_o}, 32'h1);
    chk("R2 rm=11 nearest", {31'b0, rnd_zero_o}, 32'h0);
  endtask

  task automatic t_round_modes();
    do_load(32'h1);
    chk("R2 rm=01 zero", {31'b0, rnd_zero_o}, 32'h1);
    chk("R3 flush off", {31'b0, flush_zero_o}, 32'h0);
    do_load(32'h2);
    chk("R2 rm=10 nearest", {31'b0, rnd_zero_o}, 32'h0);
    do_load(32'h0);
    chk("R2 rm=00 nearest", {31'b0, rnd_zero_o}, 32'h0);
    do_load(32'h0004_0000);
    chk("R3 dn bit", {31'b0, flush_zero_o}, 32'h1);
  endtask

  task automatic t_flag_clear();
    do_load(32'h0000_007D);
    do_upd(5'b0);
    chk("R4 flags cleared, rm kept", csr_o, 32'h0000_0001);
    chk("R6 no exc no trap", {31'b0, trap_o}, 32'h0);
  endtask

  task automatic t_accumulate();
    do_load(32'h0);
    do_upd(5'b10000);
    chk("R5 invalid merge", csr_o, 32'h0001_0040);
    do_upd(5'b00001);
    chk("R5 cause sticky", csr_o, 32'h0001_1004);
    do_load(32'h0002_0000);
    do_upd(5'b0);
    chk("R5 cause bit17 kept", csr_o, 32'h0002_0000);
  endtask

  task automatic t_trap();
    do_load(32'h0000_0200);
    do_upd(5'b00100);
    chk("R6 ovf merge", csr_o, 32'h0000_4210);
    chk("R6 trap raised", {31'b0, trap_o}, 32'h1);
    chk("R6 trap code", {20'b0, trap_code_o}, 32'h120);
    @(negedge clk_i);
    chk("R6 single pulse", {31'b0, trap_o}, 32'h0);
    chk("R6 code idle", {20'b0, trap_code_o}, 32'h0);
    do_load(32'h0000_0200);
    do_upd(5'b00001);
    chk("R6 enable mismatch", {31'b0, trap_o}, 32'h0);
    do_load(32'h0000_4200);
    do_upd(5'b0);
    chk("R6 stale cause no exc", {31'b0, trap_o}, 32'h0);
    do_upd(5'b00001);
    chk("R6 stale cause with exc", {31'b0, trap_o}, 32'h1);
    chk("R6 csr after", csr_o, 32'h0000_5204);
  endtask

  task automatic t_priority();
    do_load(32'h0);
    ld_en_i = 1; ld_data_i = 32'h0000_0200; upd_en_i = 1; exc_i = 5'b00100;
    @(negedge clk_i);
    idle();
    chk("R9 load wins", csr_o, 32'h0000_0200);
    chk("R9 no trap", {31'b0, trap_o}, 32'h0);
  endtask

  task automatic t_compare();
    do_cmp(1'b0, 2'd1, 5'b0);
    chk("R7 eq equal", {31'b0, t_bit_o}, 32'h1);
    do_cmp(1'b1, 2'd0, 5'b0);
    chk("R7 gt less", {31'b0, t_bit_o}, 32'h0);
    do_cmp(1'b1, 2'd2, 5'b0);
    chk("R7 gt greater", {31'b0, t_bit_o}, 32'h1);
    do_cmp(1'b0, 2'd2, 5'b0);
    chk("R7 eq greater", {31'b0, t_bit_o}, 32'h0);
    do_cmp(1'b0, 2'd1, 5'b0);
    do_load(32'h0000_0800);
    do_cmp(1'b0, 2'd3, 5'b10000);
    chk("R8 t held", {31'b0, t_bit_o}, 32'h1);
    chk("R8 unordered merge", csr_o, 32'h0001_0840);
    chk("R8 unordered trap", {31'b0, trap_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_load_mask();
    t_round_modes();
    t_flag_clear();
    t_accumulate();
    t_trap();
    t_priority();
    t_compare();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule